// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for system supervision, reached through a byte-wide register port. Software sets the configuration, loads two preload values and then enables the timer. Once enabled, the timer counts a first interval and then a second one, using a prescaled copy of the clock. If software does not restart it in time, the second interval runs out. The block then raises a timeout status bit, can pulse a reset request and can drive a timeout pin.

The preload values and the reload/status register are write-protected. A write to any of them takes effect only when it comes straight after a two-write key handshake on a key register. Each handshake allows exactly one write. The configuration and control registers are not key-protected. A lock bit freezes both of them until the next reset. The timeout status bit is sticky across the ordinary reset, and only the power-on reset clears it. This lets software that restarts after a watchdog reset find out why it restarted.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst` and `por`, every register reads 0x00, and `wdt_rst`, `rst_cold` and `timeout_out` are low.
- R2: A write to a preload byte (offsets 0x00 up to 0x00+NB-1 for the first stage, 0x04 up to 0x04+NB-1 for the second, little-endian) or to the reload/status register (0x0D) takes effect only when the two writes just before it were 0x80 and then 0x86 to the key register at 0x0C.
- R3: After 0x80, any write other than 0x86 to 0x0C cancels the handshake. An opened handshake is used up by the next write, whatever that write is.
- R4: While enabled, the count drops by one per prescaler period. It first runs from the first preload value down to zero, then from the second preload value down to zero. Expiry therefore comes (pre1 + pre2 + 2) periods after enable or reload, and the count then restarts from the first preload value.
- R5: Configuration bit 2 (0x10) selects the period: 0 gives 2^FINE_SHIFT clocks and 1 gives 2^COARSE_SHIFT clocks.
- R6: On expiry, `wdt_rst` pulses for exactly one cycle if configuration bit 4 is set. `timeout_out` equals the status bit ANDed with configuration bit 5. `rst_cold` follows configuration bit 3.
- R7: Expiry sets status bit 1 of 0x0D. A keyed write with bit 1 set clears it. `rst` leaves it unchanged, and only `por` clears it.
- R8: A keyed write to 0x0D with bit 0 set restarts the first stage from the first preload value and restarts the prescaler.
- R9: Once control bit 0 (0x18) is set, writes to 0x10 and to 0x18 are ignored until `rst`.
- R10: While control bit 1 is 0, the timer is parked: the count holds the first preload value and no expiry occurs.
- R11: With control bit 2 set, the timer halts after one expiry and stays parked until a reload.
- R12: Offsets 0x14 up to 0x14+NB-1 read the live count, little-endian, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for everything except the status bit |
| por | input | 1 | Synchronous active-high power-on reset for the status bit |
| addr | input | 8 | Register offset, used for writes and reads |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one byte per cycle |
| rdata | output | 8 | Read data for `addr` (combinational) |
| wdt_rst | output | 1 | One-cycle reset request on expiry |
| rst_cold | output | 1 | Reset type select |
| timeout_out | output | 1 | Timeout pin |

## Verification
The bench attacks the key handshake in three ways: a protected write with no key, a key that a stray byte has broken, and a second protected write after a single handshake. A design that checked only the last key byte, or kept the handshake open, would let those preload bytes through. It times the first expiry to the exact cycle in both prescaler settings. An off-by-one in either stage, or a prescaler that does not restart, would move the reset pulse. It also checks that the status bit survives `rst` and that locked registers stay unchanged. It counts reset pulses in halt mode and in disabled mode, where a free-running design would give several pulses.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } unlock_e;

    typedef enum logic {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } stage_e;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    localparam logic [7:0] OFS_PRE1   = 8'h00;
    localparam logic [7:0] OFS_PRE2   = 8'h04;
    localparam logic [7:0] OFS_KEY    = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h0D;
    localparam logic [7:0] OFS_CFG    = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_CTRL   = 8'h18;

    localparam logic [7:0] CFG_MASK  = 8'h3C;
    localparam logic [7:0] CTRL_MASK = 8'h07;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       pin_en;
        logic       rst_en;
        logic       cold;
        logic       coarse;
        logic [1:0] rsv_lo;
    } cfg_t;

    typedef struct packed {
        logic [4:0] rsv;
        logic       halt;
        logic       en;
        logic       lock;
    } ctrl_t;

    function automatic logic hits_lane(input logic [7:0] a, input logic [7:0] base,
                                       input int lanes);
        return (a >= base) && (a < base + 8'(lanes));
    endfunction

endpackage

// File: rtl/keyed_watchdog_unlock.sv
module keyed_watchdog_unlock
    import keyed_watchdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       open
);
    unlock_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= UL_IDLE;
        end else if (wr) begin
            if (addr == OFS_KEY && wdata == KEY_FIRST)
                state <= UL_HALF;
            else if (state == UL_HALF && addr == OFS_KEY && wdata == KEY_SECOND)
                state <= UL_OPEN;
            else
                state <= UL_IDLE;
        end
    end

    assign open = (state == UL_OPEN);

    assert_consume_R3: assert property (@(posedge clk) disable iff (rst)
        (state == UL_OPEN && wr) |=> (state != UL_OPEN));

endmodule

// File: rtl/keyed_watchdog_prescale.sv
module keyed_watchdog_prescale #(
    parameter int FINE_SHIFT   = 5,
    parameter int COARSE_SHIFT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    input  logic coarse,
    output logic tick
);
    logic [COARSE_SHIFT-1:0] psc;

    always_ff @(posedge clk) begin
        if (rst || clr || !run)
            psc <= '0;
        else
            psc <= psc + 1'b1;
    end

    assign tick = run && !clr && (coarse ? (&psc) : (&psc[FINE_SHIFT-1:0]));

endmodule

// File: rtl/keyed_watchdog_core.sv
module keyed_watchdog_core
    import keyed_watchdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             halt_mode,
    input  logic             reload,
    input  logic             tick,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic [CNT_W-1:0] count,
    output logic             halted,
    output logic             expire,
    output logic             rst_pulse
);
    stage_e stage;

    assign expire = en && !reload && !halted && tick &&
                    (count == '0) && (stage == ST_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            stage     <= ST_FIRST;
            halted    <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= 1'b0;
            if (!en || reload) begin
                count  <= pre1;
                stage  <= ST_FIRST;
                halted <= 1'b0;
            end else if (tick && !halted) begin
                if (count != '0) begin
                    count <= count - 1'b1;
                end else if (stage == ST_FIRST) begin
                    stage <= ST_SECOND;
                    count <= pre2;
                end else begin
                    stage     <= ST_FIRST;
                    count     <= pre1;
                    halted    <= halt_mode;
                    rst_pulse <= rst_en;
                end
            end
        end
    end

    assert_one_shot_R6: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse);

    assert_parked_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> !rst_pulse);

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (halted && en && !reload) |=> $stable(count));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import keyed_watchdog_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int FINE_SHIFT   = 5,
    parameter int COARSE_SHIFT = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr,
    output logic [7:0] rdata,
    output logic       wdt_rst,
    output logic       rst_cold,
    output logic       timeout_out
);
    localparam int NB = CNT_W / 8;

    logic [NB-1:0][7:0] pre1_q;
    logic [NB-1:0][7:0] pre2_q;
    cfg_t               cfg_q;
    ctrl_t              ctrl_q;
    logic               flag_q;
    logic               ul_open;
    logic               key_wr;
    logic               reload;
    logic               flag_clr;
    logic               tick;
    logic               halted;
    logic               expire;
    logic [CNT_W-1:0]   count;

    keyed_watchdog_unlock u_unlock (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .addr (addr),
        .wdata(wdata),
        .open (ul_open)
    );

    assign key_wr   = wr && ul_open;
    assign reload   = key_wr && addr == OFS_STATUS && wdata[0];
    assign flag_clr = key_wr && addr == OFS_STATUS && wdata[1];

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                pre1_q[b] <= '0;
                pre2_q[b] <= '0;
            end else if (key_wr) begin
                if (addr == OFS_PRE1 + 8'(b)) pre1_q[b] <= wdata;
                if (addr == OFS_PRE2 + 8'(b)) pre2_q[b] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            ctrl_q <= '0;
        end else if (wr && !ctrl_q.lock) begin
            if (addr == OFS_CFG)  cfg_q  <= cfg_t'(wdata & CFG_MASK);
            if (addr == OFS_CTRL) ctrl_q <= ctrl_t'(wdata & CTRL_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (por)           flag_q <= 1'b0;
        else if (expire)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    keyed_watchdog_prescale #(
        .FINE_SHIFT  (FINE_SHIFT),
        .COARSE_SHIFT(COARSE_SHIFT)
    ) u_prescale (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.en && !halted),
        .clr   (reload),
        .coarse(cfg_q.coarse),
        .tick  (tick)
    );

    keyed_watchdog_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl_q.en),
        .halt_mode(ctrl_q.halt),
        .reload   (reload),
        .tick     (tick),
        .rst_en   (cfg_q.rst_en),
        .pre1     (pre1_q),
        .pre2     (pre2_q),
        .count    (count),
        .halted   (halted),
        .expire   (expire),
        .rst_pulse(wdt_rst)
    );

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr == OFS_PRE1 + 8'(b))  rdata = pre1_q[b];
            if (addr == OFS_PRE2 + 8'(b))  rdata = pre2_q[b];
            if (addr == OFS_COUNT + 8'(b)) rdata = count[8*b +: 8];
        end
        if (addr == OFS_STATUS) rdata = {6'b0, flag_q, 1'b0};
        if (addr == OFS_CFG)    rdata = cfg_q;
        if (addr == OFS_CTRL)   rdata = ctrl_q;
    end

    assign rst_cold    = cfg_q.cold;
    assign timeout_out = flag_q && cfg_q.pin_en;

    assert_guard_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && !ul_open) |=> ($stable(pre1_q) && $stable(pre2_q)));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (por)
        (flag_q && !flag_clr) |=> flag_q);

    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> ($stable(cfg_q) && $stable(ctrl_q)));

    initial assert_lanes_R12: assert (CNT_W % 8 == 0 && NB >= 1 && NB <= 4);

endmodule

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;

    localparam int CNT_W = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       wdt_rst;
    logic       rst_cold;
    logic       timeout_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    keyed_watchdog #(.CNT_W(CNT_W), .FINE_SHIFT(1), .COARSE_SHIFT(3)) u_dut (
        .clk(clk), .rst(rst), .por(por), .addr(addr), .wdata(wdata), .wr(wr),
        .rdata(rdata), .wdt_rst(wdt_rst), .rst_cold(rst_cold), .timeout_out(timeout_out)
    );

    // monitor: pops expected register reads and compares them
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            n_run++;
            if (rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: reg 0x%02h actual 0x%02h expected 0x%02h",
                         it.tag, it.a, rdata, it.exp);
            end
        end
    end

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        addr = a;
        it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk(input string tag, input int act, input int e);
        n_run++;
        if (act != e) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, e);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic key_open();
        wr_byte(8'h0C, 8'h80);
        wr_byte(8'h0C, 8'h86);
    endtask

    task automatic wait_pulse(input int limit, output int k);
        k = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (wdt_rst) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic count_pulses(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (wdt_rst) n++;
        end
    endtask

    task automatic do_reset(input bit with_por);
        @(negedge clk);
        rst = 1'b1; por = with_por;
        repeat (2) @(negedge clk);
        rst = 1'b0; por = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        int k;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;

        // R1 reset state
        expect_reg(8'h10, 8'h00, "R1 cfg");
        expect_reg(8'h18, 8'h00, "R1 ctrl");
        expect_reg(8'h0D, 8'h00, "R1 status");
        expect_reg(8'h14, 8'h00, "R1 count");
        chk("R1 outputs", {wdt_rst, rst_cold, timeout_out}, 0);

        // R2 protected write without key is dropped, with key it lands
        wr_byte(8'h00, 8'h05);
        expect_reg(8'h00, 8'h00, "R2 unkeyed preload");
        key_open();
        wr_byte(8'h00, 8'h03);
        expect_reg(8'h00, 8'h03, "R2 keyed preload");

        // R3 one handshake allows one write; broken handshake cancels
        wr_byte(8'h01, 8'h12);
        expect_reg(8'h01, 8'h00, "R3 key consumed");
        wr_byte(8'h0C, 8'h80);
        wr_byte(8'h0C, 8'h55);
        wr_byte(8'h0C, 8'h86);
        wr_byte(8'h04, 8'h02);
        expect_reg(8'h04, 8'h00, "R3 key cancelled");
        key_open();
        wr_byte(8'h04, 8'h02);
        expect_reg(8'h04, 8'h02, "R2 keyed preload2");

        // R4 R6 first expiry timing with fine prescaler (2 clocks)
        wr_byte(8'h10, 8'h30);
        expect_reg(8'h10, 8'h30, "R6 cfg readback");
        wr_byte(8'h18, 8'h02);
        wait_pulse(60, k);
        chk("R4 expiry cycle (3+2+2)*2", k, 14);
        chk("R6 timeout pin", timeout_out, 1);
        expect_reg(8'h14, 8'h03, "R4 restart from pre1");
        chk("R6 one-cycle pulse", wdt_rst, 0);
        expect_reg(8'h0D, 8'h02, "R7 status set");

        // R7 keyed clear
        wr_byte(8'h18, 8'h00);
        key_open();
        wr_byte(8'h0D, 8'h02);
        expect_reg(8'h0D, 8'h00, "R7 status cleared");
        chk("R6 pin follows status", timeout_out, 0);

        // R8 reload restarts countdown
        wr_byte(8'h18, 8'h02);
        repeat (5) @(negedge clk);
        key_open();
        wr_byte(8'h0D, 8'h01);
        expect_reg(8'h14, 8'h03, "R8 reload count");
        wait_pulse(60, k);
        chk("R8 expiry after reload", (k > 0) ? 1 : 0, 1);

        // R7 status survives rst, cleared by por
        do_reset(1'b0);
        expect_reg(8'h0D, 8'h02, "R7 survives rst");
        expect_reg(8'h10, 8'h00, "R1 cfg after rst");
        do_reset(1'b1);
        expect_reg(8'h0D, 8'h00, "R7 por clears");

        // R9 lock freezes cfg and ctrl
        wr_byte(8'h10, 8'h10);
        wr_byte(8'h18, 8'h03);
        wr_byte(8'h10, 8'h00);
        expect_reg(8'h10, 8'h10, "R9 cfg frozen");
        wr_byte(8'h18, 8'h00);
        expect_reg(8'h18, 8'h03, "R9 ctrl frozen");
        do_reset(1'b1);

        // R11 halt mode: one expiry only
        key_open();
        wr_byte(8'h00, 8'h01);
        wr_byte(8'h10, 8'h10);
        wr_byte(8'h18, 8'h06);
        count_pulses(40, n);
        chk("R11 halt single pulse", n, 1);
        expect_reg(8'h14, 8'h01, "R11 parked count");

        // R10 disabled: parked, no expiry; R12 count read-only
        wr_byte(8'h18, 8'h00);
        key_open();
        wr_byte(8'h14, 8'hFF);
        expect_reg(8'h14, 8'h01, "R12 count write ignored");
        expect_reg(8'h15, 8'h00, "R12 count upper byte");
        count_pulses(30, n);
        chk("R10 no expiry while disabled", n, 0);

        // R5 coarse prescaler (8 clocks), R6 reset type pin
        wr_byte(8'h10, 8'h1C);
        chk("R6 rst_cold", rst_cold, 1);
        wr_byte(8'h18, 8'h02);
        wait_pulse(80, k);
        chk("R5 coarse expiry (1+0+2)*8", k, 24);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule